// File: doc/BRIEF.md
# Serial Port Interrupt Status Logic

This block produces the interrupt conditions for the receive and transmit FIFOs of a synchronous serial port. It takes the two FIFO fill levels, a strobe that marks a completed incoming frame, a strobe that marks a read from the receive FIFO, and the two bit-rate prescaler settings. It drives four raw status bits, four masked status bits and one combined request line.

Two of the sources are sticky events that software clears by writing ones. The first is a receive overrun: a frame arrives while the receive FIFO is already full. The second is a receive timeout: the receive FIFO holds data but nothing has been read or written for a fixed number of serial bit periods. The other two sources are live comparisons on the FIFO levels. They follow the levels directly and cannot be cleared by software.

A small register port gives access to the enable mask, the raw status, the masked status and a write-only clear location. The timeout is measured in serial bit periods, so its length in bus clocks scales with the prescaler.

Top module: `sspirq_top`

## Requirements
- R1: After reset, the enable mask, the overrun bit and the timeout bit are 0. The masked status and `irq_out` are 0. Raw bits 2 and 3 follow the FIFO levels even while reset is applied.
- R2: Raw bit 0 (overrun) reads 1 from the cycle after a clock edge that samples `rx_push` high with `rx_level` equal to DEPTH. A push at any lower level leaves the bit unchanged. Once set, the bit stays 1 until it is cleared.
- R3: Let P = max(`prescale`,1)·(`rate`+1) clocks. Raw bit 1 (timeout) becomes 1 exactly 32·P clock edges after the last edge that restarted the timer. It is still 0 one edge earlier.
- R4: The timer restarts on every edge that samples `rx_push` or `rx_pop`. It is held at zero on every edge where `rx_level` is 0. It fires at most once per idle interval: after the timeout bit is cleared, the bit stays 0 until the timer has restarted and a full period has passed again.
- R5: Raw bit 2 is 1 in the same cycle whenever `rx_level` ≥ DEPTH/2 (4 with the default depth of 8).
- R6: Raw bit 3 is 1 in the same cycle whenever `tx_level` ≤ DEPTH/2.
- R7: A write of value v to address 3 clears raw bit 0 if v[0]=1 and raw bit 1 if v[1]=1, effective in the next cycle. Zero bits have no effect. Bits 2 and 3 of v have no effect on raw bits 2 and 3.
- R8: An overrun or timeout event on the same edge as a clear write for that bit leaves the bit at 1.
- R9: A write to address 0 sets the mask from v[3:0], effective in the next cycle. `irq_masked` = raw AND mask. `irq_out` is the OR of the four masked bits.
- R10: Reads return the mask at address 0, the raw status at address 1 and the masked status at address 2. Address 3 reads 0. Bits 31 to 4 always read 0, and the written values of those bits are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_level | input | 4 | Receive FIFO fill level, 0 to DEPTH |
| tx_level | input | 4 | Transmit FIFO fill level, 0 to DEPTH |
| rx_push | input | 1 | One-cycle strobe: a received frame completed |
| rx_pop | input | 1 | One-cycle strobe: receive FIFO read |
| prescale | input | 8 | Clock prescale divisor (0 is treated as 1) |
| rate | input | 8 | Serial clock rate factor; bit period = prescale·(rate+1) |
| reg_sel | input | 2 | Register address: 0 mask, 1 raw, 2 masked, 3 clear |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_sel` |
| irq_raw | output | 4 | Raw status: overrun, timeout, rx half full, tx half empty |
| irq_masked | output | 4 | Raw status ANDed with the mask |
| irq_out | output | 1 | OR of the masked status bits |

## Verification
The level bits, the masked bits and the read data are combinational from their inputs and registers, so they are due in the same cycle as the stimulus. A mask write, a clear write and an overrun strobe take effect one clock edge later. The timeout rises exactly 32·P edges after the edge that last restarted the timer, or after the last edge that saw an empty FIFO. The bench drives all inputs on the falling edge and samples combinational results 1 ns after driving them. It samples registered results on the falling edge after the edge that updates them, and for each prescaler setting it checks the timeout bit on the last edge before it is due and again on the edge it is due.

// File: rtl/sspirq_pkg.sv
package sspirq_pkg;
   localparam int unsigned NSRC    = 4;
   localparam int unsigned SRC_OVR = 0;
   localparam int unsigned SRC_TMO = 1;
   localparam int unsigned SRC_RXH = 2;
   localparam int unsigned SRC_TXH = 3;

   typedef enum logic [1:0] {
      ADDR_MASK = 2'd0,
      ADDR_RAW  = 2'd1,
      ADDR_MIS  = 2'd2,
      ADDR_CLR  = 2'd3
   } reg_addr_e;
endpackage

// File: rtl/sspirq_bittick.sv
module sspirq_bittick #(
   parameter int unsigned PS_W  = 8,
   parameter int unsigned SCR_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic [PS_W-1:0]  prescale,
   input  logic [SCR_W-1:0] rate,
   output logic             tick
);
   localparam int unsigned PER_W = PS_W + SCR_W;

   logic [PS_W-1:0]  ps_eff;
   logic [PER_W-1:0] period, period_m1, cnt_q;

   always_comb begin
      ps_eff    = (prescale == '0) ? PS_W'(1) : prescale;
      period    = PER_W'(ps_eff) * (PER_W'(rate) + PER_W'(1));
      period_m1 = period - PER_W'(1);
   end

   assign tick = (cnt_q >= period_m1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt_q <= '0;
      else if (restart) cnt_q <= '0;
      else if (tick)    cnt_q <= '0;
      else              cnt_q <= cnt_q + PER_W'(1);
   end

   AST_NO_EARLY_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      (restart && period_m1 != '0 && $stable(prescale) && $stable(rate))
      |=> !tick); // R3
endmodule

// File: rtl/sspirq_rxtimeout.sv
module sspirq_rxtimeout #(
   parameter int unsigned TO_BITS = 32
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   input  logic rx_empty,
   input  logic tick,
   output logic to_evt
);
   localparam int unsigned CNT_W = $clog2(TO_BITS + 1);

   logic [CNT_W-1:0] cnt_q;
   logic             done;

   assign done   = (cnt_q == CNT_W'(TO_BITS));
   assign to_evt = !restart && tick && (cnt_q == CNT_W'(TO_BITS - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               cnt_q <= '0;
      else if (restart)         cnt_q <= '0;
      else if (tick && !done)   cnt_q <= cnt_q + CNT_W'(1);
   end

   AST_HOLD_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      rx_empty |=> (cnt_q == '0)); // R4
endmodule

// File: rtl/sspirq_regs.sv
module sspirq_regs
   import sspirq_pkg::*;
#(
   parameter int unsigned DW = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [1:0]      reg_sel,
   input  logic            reg_wr,
   input  logic [DW-1:0]   reg_wdata,
   input  logic            ovr_evt,
   input  logic            to_evt,
   input  logic            rxh,
   input  logic            txh,
   output logic [NSRC-1:0] raw,
   output logic [NSRC-1:0] masked,
   output logic [DW-1:0]   rdata
);
   logic [NSRC-1:0] mask_q;
   logic [1:0]      sticky_q, clr;
   logic            wr_mask, wr_rsvd;

   assign wr_mask = reg_wr && (reg_sel == ADDR_MASK);
   assign wr_rsvd = |reg_wdata[DW-1:NSRC];
   assign clr     = (reg_wr && reg_sel == ADDR_CLR) ? reg_wdata[1:0] : 2'b00;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q   <= '0;
         sticky_q <= '0;
      end else begin
         if (wr_mask) mask_q <= reg_wdata[NSRC-1:0];
         sticky_q <= (sticky_q & ~clr) | {to_evt, ovr_evt};
      end
   end

   always_comb begin
      raw          = '0;
      raw[SRC_OVR] = sticky_q[0];
      raw[SRC_TMO] = sticky_q[1];
      raw[SRC_RXH] = rxh;
      raw[SRC_TXH] = txh;
      masked       = raw & mask_q;
   end

   always_comb begin
      case (reg_addr_e'(reg_sel))
         ADDR_MASK: rdata = DW'(mask_q);
         ADDR_RAW:  rdata = DW'(raw);
         ADDR_MIS:  rdata = DW'(masked);
         default:   rdata = '0;
      endcase
   end

   AST_OVR_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      ovr_evt |=> raw[SRC_OVR]); // R2
   AST_OVR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!ovr_evt && !clr[0]) |=> (raw[SRC_OVR] == $past(raw[SRC_OVR]))); // R2
   AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      (clr[0] && !ovr_evt) |=> !raw[SRC_OVR]); // R7
   AST_EVT_BEATS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      (to_evt && clr[1]) |=> raw[SRC_TMO]); // R8
   AST_RSVD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_mask && wr_rsvd) |=> (rdata[DW-1:NSRC] == '0 &&
                                masked == (raw & $past(reg_wdata[NSRC-1:0])))); // R10
endmodule

// File: rtl/sspirq_top.sv
module sspirq_top
   import sspirq_pkg::*;
#(
   parameter int unsigned DEPTH   = 8,
   parameter int unsigned DW      = 32,
   parameter int unsigned PS_W    = 8,
   parameter int unsigned SCR_W   = 8,
   parameter int unsigned TO_BITS = 32,
   parameter bit          REG_IRQ = 1'b0,
   localparam int unsigned LVL_W  = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LVL_W-1:0] rx_level,
   input  logic [LVL_W-1:0] tx_level,
   input  logic             rx_push,
   input  logic             rx_pop,
   input  logic [PS_W-1:0]  prescale,
   input  logic [SCR_W-1:0] rate,
   input  logic [1:0]       reg_sel,
   input  logic             reg_wr,
   input  logic [DW-1:0]    reg_wdata,
   output logic [DW-1:0]    reg_rdata,
   output logic [NSRC-1:0]  irq_raw,
   output logic [NSRC-1:0]  irq_masked,
   output logic             irq_out
);
   localparam int unsigned HALF = DEPTH / 2;

   if (DEPTH < 2 || (DEPTH % 2) != 0) begin : g_bad_depth
      $error("sspirq_top: DEPTH must be even and at least 2");
   end
   if (DW < NSRC) begin : g_bad_dw
      $error("sspirq_top: DW must hold all status bits");
   end
   if (TO_BITS < 1) begin : g_bad_to
      $error("sspirq_top: TO_BITS must be at least 1");
   end
   if (PS_W < 1 || SCR_W < 1) begin : g_bad_ps
      $error("sspirq_top: prescaler widths must be nonzero");
   end

   logic rx_empty, restart, tick, to_evt, ovr_evt, rxh, txh;

   assign rx_empty = (rx_level == '0);
   assign restart  = rx_empty || rx_push || rx_pop;
   assign ovr_evt  = rx_push && (rx_level == LVL_W'(DEPTH));
   assign rxh      = (rx_level >= LVL_W'(HALF));
   assign txh      = (tx_level <= LVL_W'(HALF));

   sspirq_bittick #(.PS_W(PS_W), .SCR_W(SCR_W)) u_tick (
      .clk(clk), .rst_n(rst_n), .restart(restart),
      .prescale(prescale), .rate(rate), .tick(tick)
   );

   sspirq_rxtimeout #(.TO_BITS(TO_BITS)) u_tmo (
      .clk(clk), .rst_n(rst_n), .restart(restart),
      .rx_empty(rx_empty), .tick(tick), .to_evt(to_evt)
   );

   sspirq_regs #(.DW(DW)) u_regs (
      .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .ovr_evt(ovr_evt), .to_evt(to_evt),
      .rxh(rxh), .txh(txh), .raw(irq_raw), .masked(irq_masked),
      .rdata(reg_rdata)
   );

   if (REG_IRQ) begin : g_irq_ff
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_out <= 1'b0;
         else        irq_out <= |irq_masked;
      end
   end else begin : g_irq_comb
      assign irq_out = |irq_masked;
   end
endmodule

// File: tb/sspirq_top_tb_top.sv
`timescale 1ns/1ps
module sspirq_top_tb_top;
   logic        clk = 1'b0;
   logic        rst_n;
   logic [3:0]  rx_level, tx_level;
   logic        rx_push, rx_pop;
   logic [7:0]  prescale, rate;
   logic [1:0]  reg_sel;
   logic        reg_wr;
   logic [31:0] reg_wdata, reg_rdata;
   logic [3:0]  irq_raw, irq_masked;
   logic        irq_out;

   int tests = 0;
   int fails = 0;
   bit done  = 1'b0;

   always #5 clk = ~clk;

   sspirq_top dut_i (
      .clk(clk), .rst_n(rst_n), .rx_level(rx_level), .tx_level(tx_level),
      .rx_push(rx_push), .rx_pop(rx_pop), .prescale(prescale), .rate(rate),
      .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .irq_raw(irq_raw), .irq_masked(irq_masked),
      .irq_out(irq_out)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_sel = a; reg_wr = 1'b1; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic reg_read_chk(input string req, input logic [1:0] a, input logic [31:0] exp);
      reg_sel = a;
      #1;
      chk(req, reg_rdata, exp);
   endtask

   task automatic pulse_push();
      @(negedge clk); rx_push = 1'b1;
      @(negedge clk); rx_push = 1'b0;
   endtask

   // restart the timer with a pop or push, clear the timeout bit, then check the deadline
   task automatic run_timeout(input int ps, input int sr, input bit use_push, input string req);
      int p;
      p = ((ps == 0) ? 1 : ps) * (sr + 1);
      @(negedge clk);
      prescale = 8'(ps); rate = 8'(sr);
      if (use_push) rx_push = 1'b1; else rx_pop = 1'b1;
      reg_sel = 2'd3; reg_wr = 1'b1; reg_wdata = 32'h2;
      @(negedge clk);
      rx_push = 1'b0; rx_pop = 1'b0; reg_wr = 1'b0;
      repeat (32 * p - 1) @(negedge clk);
      chk({req, " not before 32 bit periods"}, 32'(irq_raw[1]), 32'd0);
      @(negedge clk);
      chk({req, " at 32 bit periods"}, 32'(irq_raw[1]), 32'd1);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         tests++; fails++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      logic [3:0] raw_exp;
      rst_n = 1'b0; rx_level = '0; tx_level = '0; rx_push = 1'b0; rx_pop = 1'b0;
      prescale = 8'd255; rate = 8'd255; reg_sel = '0; reg_wr = 1'b0; reg_wdata = '0;
      repeat (3) @(negedge clk);
      // R1: reset state (tx level 0 makes bit 3 live)
      chk("R1 raw during reset", 32'(irq_raw), 32'h8);
      chk("R1 masked during reset", 32'(irq_masked), 32'h0);
      chk("R1 irq_out during reset", 32'(irq_out), 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      reg_read_chk("R1 mask after reset", 2'd0, 32'h0);
      chk("R1 raw after reset", 32'(irq_raw), 32'h8);

      // R5 / R6: sweep both levels
      for (int rl = 0; rl <= 8; rl++) begin
         for (int tl = 0; tl <= 8; tl++) begin
            @(negedge clk);
            rx_level = 4'(rl); tx_level = 4'(tl);
            #1;
            chk("R5 rx half-full bit", 32'(irq_raw[2]), 32'(rl >= 4));
            chk("R6 tx half-empty bit", 32'(irq_raw[3]), 32'(tl <= 4));
         end
      end

      // R2: overrun
      @(negedge clk); rx_level = 4'd8; tx_level = 4'd5;
      #1; chk("R2 overrun clear before push", 32'(irq_raw[0]), 32'd0);
      pulse_push();
      chk("R2 overrun set on full push", 32'(irq_raw[0]), 32'd1);
      repeat (5) @(negedge clk);
      chk("R2 overrun sticky", 32'(irq_raw[0]), 32'd1);
      reg_write(2'd3, 32'h0);
      chk("R7 zero write keeps overrun", 32'(irq_raw[0]), 32'd1);
      reg_write(2'd3, 32'h1);
      chk("R7 clear overrun", 32'(irq_raw[0]), 32'd0);
      @(negedge clk); rx_level = 4'd7;
      pulse_push();
      chk("R2 push below full no overrun", 32'(irq_raw[0]), 32'd0);
      @(negedge clk); rx_level = 4'd8; tx_level = 4'd2;
      reg_write(2'd3, 32'hC);
      chk("R7 level bits not clearable", 32'(irq_raw[3:2]), 32'h3);
      // R8: event on the same edge as the clear
      @(negedge clk);
      rx_push = 1'b1; reg_sel = 2'd3; reg_wr = 1'b1; reg_wdata = 32'h1;
      @(negedge clk);
      rx_push = 1'b0; reg_wr = 1'b0;
      chk("R8 overrun beats clear", 32'(irq_raw[0]), 32'd1);

      // R9 / R10: mask sweep with raw = 1101
      @(negedge clk); tx_level = 4'd3;
      raw_exp = 4'b1101;
      #1; chk("R9 raw pattern", 32'(irq_raw), 32'(raw_exp));
      for (int m = 0; m < 16; m++) begin
         reg_write(2'd0, 32'hFFFF_FFF0 | 32'(m));
         #1;
         chk("R9 masked status", 32'(irq_masked), 32'(raw_exp & 4'(m)));
         chk("R9 combined request", 32'(irq_out), 32'(|(raw_exp & 4'(m))));
         reg_read_chk("R10 mask readback, reserved ignored", 2'd0, 32'(m));
         reg_read_chk("R10 raw readback", 2'd1, 32'(raw_exp));
         reg_read_chk("R10 masked readback", 2'd2, 32'(raw_exp & 4'(m)));
         reg_read_chk("R10 clear address reads zero", 2'd3, 32'h0);
      end
      reg_write(2'd3, 32'h1);
      @(negedge clk); rx_level = 4'd3; tx_level = 4'd5;

      // R3: timeout for several prescaler settings
      run_timeout(1, 0, 1'b0, "R3 P=1");
      run_timeout(2, 0, 1'b0, "R3 P=2");
      run_timeout(2, 1, 1'b0, "R3 P=4");
      run_timeout(3, 1, 1'b0, "R3 P=6");
      run_timeout(4, 2, 1'b0, "R3 P=12");
      run_timeout(0, 1, 1'b0, "R3 prescale 0 as 1");

      // R4: pop restarts mid count
      @(negedge clk); rx_pop = 1'b1;
      @(negedge clk); rx_pop = 1'b0;
      repeat (20) @(negedge clk);
      run_timeout(1, 0, 1'b0, "R4 pop restart");
      // R4: push restarts mid count
      @(negedge clk); rx_pop = 1'b1;
      @(negedge clk); rx_pop = 1'b0;
      repeat (20) @(negedge clk);
      run_timeout(1, 0, 1'b1, "R4 push restart");
      // R4: fires once per idle interval
      reg_write(2'd3, 32'h2);
      repeat (100) @(negedge clk);
      chk("R4 no refire after clear", 32'(irq_raw[1]), 32'd0);
      // R4: held at zero while empty
      @(negedge clk); rx_level = 4'd0;
      repeat (100) @(negedge clk);
      chk("R4 no timeout while empty", 32'(irq_raw[1]), 32'd0);
      @(negedge clk); rx_level = 4'd2;
      repeat (31) @(negedge clk);
      chk("R4 empty hold, not early", 32'(irq_raw[1]), 32'd0);
      @(negedge clk);
      chk("R4 empty hold, on time", 32'(irq_raw[1]), 32'd1);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule